// File: doc/BRIEF.md
# Debug Abstract Register-Access Sequencer

This block is the register-transfer engine of a single-hart debug module. A debugger reaches it through a simple select/enable register port. That port holds a control word, one data word, an abstract command word, a small program buffer, an abstract status word and a read-only hart description. When a register-access command is written, the block leaves the halted hart's register file alone. Instead it feeds the hart a short instruction stream over a valid/ready channel. The stream is a CSR move between the chosen general-purpose register and a debug-only CSR at address 0xbff, then optionally the program-buffer words, then an `ebreak`. The block then waits for the hart to report that it caught the `ebreak`, or that it caught an exception.

The debug-only CSR is backed by the block's data word. The hart reaches it through a separate CSR-side port, and that port accepts accesses only while the hart is in debug mode. Any other access to that CSR address is flagged as illegal. The hart description word tells the debugger that the data word is CSR-mapped, that it is the only data word, and where the CSR lives.

Top module: `dbg_abs_seq`

## Requirements
- R1: After reset, the data word reads 0, the control word reads 0, the abstract status word reads 0x02000001 (busy clear, error 0), `halt_req` is 0 and `inj_valid` is 0.
- R2: A write to port address 0x10 sets the active bit from data bit 0 and the halt-request bit from data bit 31. `halt_req` equals active AND halt-request. Address 0x11 reads hart-halted in bits 9 and 8 and the value 2 in bits 3:0.
- R3: Address 0x12 reads the constant 0x00001bff: scratch count 0 in bits 23:20, CSR-mapped flag 0 in bit 16, data count 1 in bits 15:12, CSR address 0xbff in bits 11:0. Address 0x16 carries the constant fields program-buffer size 2 in bits 28:24 and data count 1 in bits 3:0.
- R4: The command word at 0x17 has these fields: type in 31:24, reserved bit 23, access size in 22:20, reserved bit 19, post-execute in 18, transfer in 17, write in 16 and register number in 15:0, with GPR n at 0x1000+n. A transfer with write=1 injects 0xbff02073 | (n<<7), which moves the data word into xn, and then `ebreak` (0x00100073).
- R5: A transfer with write=0 injects 0xbff01073 | (n<<15), which moves xn into the data word, and then `ebreak`. After completion the data word at 0x04 holds the value the hart wrote.
- R6: With post-execute set, program-buffer words 0 (address 0x20) and 1 (address 0x21) are injected in that order after the transfer instruction. If the transfer bit is clear, they are injected alone. `ebreak` always comes last. A presented instruction stays valid and unchanged until the hart accepts it.
- R7: Abstract status bit 12 (busy) is set from the cycle after an accepted command until the hart reports the caught `ebreak`. A command written while busy injects nothing extra and sets the error field (bits 10:8) to 1 if it was 0.
- R8: An exception reported by the hart ends the command and sets the error field to 3. The error field stays set until cleared. Writing to 0x16 clears each error bit whose data bit is 1.
- R9: A command is rejected with error 2 and nothing is injected if its type is nonzero, a reserved bit is set, or it has transfer set with an access size other than 2 or a register number outside 0x1000..0x101f.
- R10: A valid command while the hart is not halted sets error 4 and injects nothing. Any command written while the error field is nonzero is ignored.
- R11: In debug mode, a hart CSR write to 0xbff updates the data word, and a hart CSR read of 0xbff returns it.
- R12: Outside debug mode, a hart read or write of 0xbff raises `hcsr_illegal` and leaves the data word unchanged. Accesses to other CSR addresses never raise it.
- R13: While the active bit is clear, `halt_req` is 0 and command writes are ignored: no injection, no busy and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_sel | input | 1 | Debug port select |
| dp_enable | input | 1 | Debug port access phase |
| dp_write | input | 1 | Debug port write strobe qualifier |
| dp_addr | input | 8 | Debug port word address |
| dp_wdata | input | 32 | Debug port write data |
| dp_rdata | output | 32 | Debug port read data |
| halt_req | output | 1 | Halt request to the hart |
| hart_halted | input | 1 | Hart reports it is halted |
| hart_dbg_mode | input | 1 | Hart is executing in debug mode |
| inj_instr | output | 32 | Injected instruction |
| inj_valid | output | 1 | Injected instruction is valid |
| inj_ready | input | 1 | Hart accepts the injected instruction |
| hart_ebreak | input | 1 | Hart caught the closing ebreak (pulse) |
| hart_exception | input | 1 | Hart caught an exception (pulse) |
| hcsr_addr | input | 12 | Hart CSR access address |
| hcsr_wen | input | 1 | Hart CSR write enable |
| hcsr_ren | input | 1 | Hart CSR read enable |
| hcsr_wdata | input | 32 | Hart CSR write data |
| hcsr_rdata | output | 32 | Data word as seen by the hart |
| hcsr_illegal | output | 1 | Hart access to the data CSR outside debug mode |

## Verification
The bench covers several command patterns: a GPR write, a GPR read, transfer followed by the program buffer, program buffer alone, a transfer at the last legal register, and malformed words that hit each rejection cause. The injected stream is captured and compared word by word, which separates opcode, field-position and ordering faults. A bench-side hart executes the CSR moves, so a wrong shift or a swapped direction shows up as wrong data in the register or in the data word. The hart's ready is driven three ways: always high, toggling, and held low. This separates a sequencer that drops or changes an unaccepted instruction from one that holds it. The held-low case also makes room for the busy-collision error. Exceptions, the halted check, per-bit error clearing and the inactive state each get their own pattern.

// File: rtl/dbg_abs_pkg.sv
package dbg_abs_pkg;

    // debug register port word addresses
    localparam logic [7:0] A_DATA0 = 8'h04;
    localparam logic [7:0] A_CTRL  = 8'h10;
    localparam logic [7:0] A_STAT  = 8'h11;
    localparam logic [7:0] A_HINFO = 8'h12;
    localparam logic [7:0] A_ACS   = 8'h16;
    localparam logic [7:0] A_CMD   = 8'h17;
    localparam logic [7:0] A_PB0   = 8'h20;

    localparam logic [31:0] OP_EBREAK = 32'h00100073;
    localparam logic [6:0]  OP_SYSTEM = 7'h73;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_BUSY  = 3'd1,
        ERR_UNSUP = 3'd2,
        ERR_EXC   = 3'd3,
        ERR_HALT  = 3'd4
    } cmderr_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_XFER,
        SQ_PROG,
        SQ_EBRK,
        SQ_WAIT
    } seq_e;

    typedef struct packed {
        logic [7:0]  ctype;
        logic        rsv_hi;
        logic [2:0]  size;
        logic        rsv_lo;
        logic        postexec;
        logic        transfer;
        logic        wr;
        logic [15:0] regno;
    } acmd_t;

    // CSR move between a GPR and a CSR: wr=1 reads the CSR into the GPR,
    // wr=0 writes the GPR into the CSR.
    function automatic logic [31:0] csr_move(logic [11:0] csr, logic wr, logic [4:0] gpr);
        if (wr)
            return {csr, 5'd0, 3'b010, gpr, OP_SYSTEM};
        else
            return {csr, gpr, 3'b001, 5'd0, OP_SYSTEM};
    endfunction

endpackage

// File: rtl/dbg_abs_cmd_check.sv
module dbg_abs_cmd_check
    import dbg_abs_pkg::*;
#(
    parameter int unsigned NUM_GPR  = 32,
    parameter int unsigned GPR_BASE = 16'h1000,
    localparam int unsigned IDXW    = $clog2(NUM_GPR)
) (
    input  logic [31:0]     cmd_word,
    input  logic            halted,
    output cmderr_e         verdict,
    output logic            go_xfer,
    output logic            go_prog,
    output logic            go_wr,
    output logic [IDXW-1:0] go_gpr
);
    acmd_t       c;
    logic [16:0] off;
    logic        in_range;
    logic        malformed;

    always_comb begin
        c         = acmd_t'(cmd_word);
        off       = {1'b0, c.regno} - 17'(GPR_BASE);
        in_range  = (c.regno >= 16'(GPR_BASE)) && (off < 17'(NUM_GPR));
        malformed = (c.ctype != 8'd0) || c.rsv_hi || c.rsv_lo ||
                    (c.transfer && ((c.size != 3'd2) || !in_range));
        if (malformed)
            verdict = ERR_UNSUP;
        else if (!halted)
            verdict = ERR_HALT;
        else
            verdict = ERR_NONE;
        go_xfer = c.transfer;
        go_prog = c.postexec;
        go_wr   = c.wr;
        go_gpr  = off[IDXW-1:0];
    end

endmodule

// File: rtl/dbg_abs_inject.sv
module dbg_abs_inject
    import dbg_abs_pkg::*;
#(
    parameter int unsigned NPB      = 2,
    parameter int unsigned NUM_GPR  = 32,
    parameter logic [11:0] DATA_CSR = 12'hbff,
    localparam int unsigned IDXW    = $clog2(NUM_GPR),
    localparam int unsigned PBW     = (NPB > 1) ? $clog2(NPB) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 go_xfer,
    input  logic                 go_prog,
    input  logic                 go_wr,
    input  logic [IDXW-1:0]      go_gpr,
    input  logic [NPB-1:0][31:0] pbuf,
    input  logic                 ready,
    input  logic                 caught_ebreak,
    input  logic                 caught_exc,
    output logic [31:0]          instr,
    output logic                 valid,
    output logic                 busy,
    output logic                 exc_end
);
    typedef struct packed {
        seq_e            st;
        logic            wr;
        logic [IDXW-1:0] gpr;
        logic            post;
        logic [PBW-1:0]  pbi;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        exc_end = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start) begin
                    s_d.wr   = go_wr;
                    s_d.gpr  = go_gpr;
                    s_d.post = go_prog;
                    s_d.pbi  = '0;
                    if (go_xfer)
                        s_d.st = SQ_XFER;
                    else if (go_prog)
                        s_d.st = SQ_PROG;
                end
            end
            SQ_XFER: if (ready) s_d.st = s_q.post ? SQ_PROG : SQ_EBRK;
            SQ_PROG: begin
                if (ready) begin
                    if (s_q.pbi == PBW'(NPB - 1))
                        s_d.st = SQ_EBRK;
                    else
                        s_d.pbi = s_q.pbi + 1'b1;
                end
            end
            SQ_EBRK: if (ready) s_d.st = SQ_WAIT;
            SQ_WAIT: if (caught_ebreak) s_d.st = SQ_IDLE;
            default: s_d.st = SQ_IDLE;
        endcase
        if (s_q.st != SQ_IDLE && caught_exc) begin
            s_d.st  = SQ_IDLE;
            exc_end = 1'b1;
        end
    end

    always_comb begin
        valid = 1'b0;
        instr = OP_EBREAK;
        unique case (s_q.st)
            SQ_XFER: begin
                valid = 1'b1;
                instr = csr_move(DATA_CSR, s_q.wr, 5'(s_q.gpr));
            end
            SQ_PROG: begin
                valid = 1'b1;
                instr = pbuf[s_q.pbi];
            end
            SQ_EBRK: valid = 1'b1;
            default: ;
        endcase
        busy = (s_q.st != SQ_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{st: SQ_IDLE, wr: 1'b0, gpr: '0, post: 1'b0, pbi: '0};
        else
            s_q <= s_d;
    end

endmodule

// File: rtl/dbg_abs_hart_port.sv
module dbg_abs_hart_port #(
    parameter logic [11:0] DATA_CSR = 12'hbff
) (
    input  logic [11:0] addr,
    input  logic        wen,
    input  logic        ren,
    input  logic        dbg_mode,
    input  logic [31:0] data0,
    output logic        data0_we,
    output logic [31:0] rdata,
    output logic        illegal
);
    logic hit;

    always_comb begin
        hit      = (addr == DATA_CSR);
        data0_we = hit && wen && dbg_mode;
        rdata    = (hit && dbg_mode) ? data0 : 32'd0;
        illegal  = hit && (wen || ren) && !dbg_mode;
    end

endmodule

// File: rtl/dbg_abs_seq.sv
module dbg_abs_seq
    import dbg_abs_pkg::*;
#(
    parameter int unsigned NPB      = 2,
    parameter int unsigned NUM_GPR  = 32,
    parameter int unsigned GPR_BASE = 16'h1000,
    parameter logic [11:0] DATA_CSR = 12'hbff,
    localparam int unsigned IDXW    = $clog2(NUM_GPR)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dp_sel,
    input  logic        dp_enable,
    input  logic        dp_write,
    input  logic [7:0]  dp_addr,
    input  logic [31:0] dp_wdata,
    output logic [31:0] dp_rdata,
    output logic        halt_req,
    input  logic        hart_halted,
    input  logic        hart_dbg_mode,
    output logic [31:0] inj_instr,
    output logic        inj_valid,
    input  logic        inj_ready,
    input  logic        hart_ebreak,
    input  logic        hart_exception,
    input  logic [11:0] hcsr_addr,
    input  logic        hcsr_wen,
    input  logic        hcsr_ren,
    input  logic [31:0] hcsr_wdata,
    output logic [31:0] hcsr_rdata,
    output logic        hcsr_illegal
);
    typedef struct packed {
        logic                 active;
        logic                 haltreq;
        logic [31:0]          data0;
        logic [NPB-1:0][31:0] pb;
        logic [2:0]           cmderr;
    } regs_t;

    regs_t r_d, r_q;

    logic            bus_wr, cmd_wr, acs_wr, d0_bus_wr;
    logic            start, seq_busy, exc_end, d0_hart_we;
    cmderr_e         verdict;
    logic            go_xfer, go_prog, go_wr;
    logic [IDXW-1:0] go_gpr;
    logic [2:0]      cmderr_cur;
    logic [31:0]     data0_cur;
    logic            active_cur;

    dbg_abs_cmd_check #(.NUM_GPR(NUM_GPR), .GPR_BASE(GPR_BASE)) i_check (
        .cmd_word (dp_wdata),
        .halted   (hart_halted),
        .verdict  (verdict),
        .go_xfer  (go_xfer),
        .go_prog  (go_prog),
        .go_wr    (go_wr),
        .go_gpr   (go_gpr)
    );

    dbg_abs_inject #(.NPB(NPB), .NUM_GPR(NUM_GPR), .DATA_CSR(DATA_CSR)) i_inject (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .go_xfer       (go_xfer),
        .go_prog       (go_prog),
        .go_wr         (go_wr),
        .go_gpr        (go_gpr),
        .pbuf          (r_q.pb),
        .ready         (inj_ready),
        .caught_ebreak (hart_ebreak),
        .caught_exc    (hart_exception),
        .instr         (inj_instr),
        .valid         (inj_valid),
        .busy          (seq_busy),
        .exc_end       (exc_end)
    );

    dbg_abs_hart_port #(.DATA_CSR(DATA_CSR)) i_hport (
        .addr     (hcsr_addr),
        .wen      (hcsr_wen),
        .ren      (hcsr_ren),
        .dbg_mode (hart_dbg_mode),
        .data0    (r_q.data0),
        .data0_we (d0_hart_we),
        .rdata    (hcsr_rdata),
        .illegal  (hcsr_illegal)
    );

    always_comb begin
        bus_wr    = dp_sel && dp_enable && dp_write;
        cmd_wr    = bus_wr && (dp_addr == A_CMD) && r_q.active;
        acs_wr    = bus_wr && (dp_addr == A_ACS);
        d0_bus_wr = bus_wr && (dp_addr == A_DATA0);
        start     = cmd_wr && !seq_busy && (r_q.cmderr == 3'd0) && (verdict == ERR_NONE)
                    && (go_xfer || go_prog);
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr && dp_addr == A_CTRL) begin
            r_d.active  = dp_wdata[0];
            r_d.haltreq = dp_wdata[31];
        end
        if (d0_bus_wr)
            r_d.data0 = dp_wdata;
        if (d0_hart_we)
            r_d.data0 = hcsr_wdata;
        for (int i = 0; i < NPB; i++) begin
            if (bus_wr && dp_addr == A_PB0 + 8'(i))
                r_d.pb[i] = dp_wdata;
        end
        if (acs_wr)
            r_d.cmderr = r_d.cmderr & ~dp_wdata[10:8];
        if (cmd_wr && r_q.cmderr == 3'd0) begin
            if (seq_busy)
                r_d.cmderr = 3'(ERR_BUSY);
            else if (verdict != ERR_NONE)
                r_d.cmderr = 3'(verdict);
        end
        if (exc_end && r_q.cmderr == 3'd0)
            r_d.cmderr = 3'(ERR_EXC);
    end

    always_comb begin
        dp_rdata = 32'd0;
        unique case (dp_addr)
            A_DATA0: dp_rdata = r_q.data0;
            A_CTRL:  dp_rdata = {r_q.haltreq, 30'd0, r_q.active};
            A_STAT:  dp_rdata = {22'd0, hart_halted, hart_halted, 4'd0, 4'd2};
            A_HINFO: dp_rdata = {8'd0, 4'd0, 3'd0, 1'b0, 4'd1, DATA_CSR};
            A_ACS:   dp_rdata = {3'd0, 5'(NPB), 11'd0, seq_busy, 1'b0, r_q.cmderr, 4'd0, 4'd1};
            default: begin
                for (int i = 0; i < NPB; i++) begin
                    if (dp_addr == A_PB0 + 8'(i))
                        dp_rdata = r_q.pb[i];
                end
            end
        endcase
        halt_req   = r_q.active && r_q.haltreq;
        cmderr_cur = r_q.cmderr;
        data0_cur  = r_q.data0;
        active_cur = r_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

endmodule

// File: rtl/dbg_abs_checker.sv
module dbg_abs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        inj_valid,
    input logic        inj_ready,
    input logic [31:0] inj_instr,
    input logic        hart_exception,
    input logic        busy,
    input logic [2:0]  cmderr,
    input logic        acs_wr,
    input logic        hcsr_wen,
    input logic        hcsr_ren,
    input logic        hcsr_illegal,
    input logic        hart_dbg_mode,
    input logic        d0_bus_wr,
    input logic [31:0] data0,
    input logic        active,
    input logic        halt_req
);
    a_r6_hold_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && !inj_ready && !hart_exception) |=> (inj_valid && $stable(inj_instr)));

    a_r7_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> busy);

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmderr != 3'd0 && !acs_wr) |=> $stable(cmderr));

    a_r12_illegal_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hcsr_illegal |-> (!hart_dbg_mode && (hcsr_wen || hcsr_ren)));

    a_r12_data_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (hcsr_wen && !hart_dbg_mode && !d0_bus_wr) |=> $stable(data0));

    a_r13_no_halt_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !halt_req);

endmodule

bind dbg_abs_seq dbg_abs_checker i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .inj_valid      (inj_valid),
    .inj_ready      (inj_ready),
    .inj_instr      (inj_instr),
    .hart_exception (hart_exception),
    .busy           (seq_busy),
    .cmderr         (cmderr_cur),
    .acs_wr         (acs_wr),
    .hcsr_wen       (hcsr_wen),
    .hcsr_ren       (hcsr_ren),
    .hcsr_illegal   (hcsr_illegal),
    .hart_dbg_mode  (hart_dbg_mode),
    .d0_bus_wr      (d0_bus_wr),
    .data0          (data0_cur),
    .active         (active_cur),
    .halt_req       (halt_req)
);

// File: tb/test_dbg_abs_seq.sv
module test_dbg_abs_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        sel = 0, en = 0, wr = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] dp_rdata;
    logic        halt_req, halted = 0, dbgm = 0;
    logic [31:0] inj_instr;
    logic        inj_valid, ready = 0, ebk = 0, exc = 0;
    logic        t_wen = 0, t_ren = 0, m_wen = 0, m_ren = 0;
    logic [11:0] t_addr = 0, m_addr = 0;
    logic [31:0] t_wdata = 0, m_wdata = 0;
    logic [31:0] hcsr_rdata;
    logic        hcsr_illegal;

    wire         hcsr_wen   = t_wen | m_wen;
    wire         hcsr_ren   = t_ren | m_ren;
    wire  [11:0] hcsr_addr  = (t_wen | t_ren) ? t_addr : m_addr;
    wire  [31:0] hcsr_wdata = (t_wen | t_ren) ? t_wdata : m_wdata;

    dbg_abs_seq i_dbg_abs_seq (
        .clk(clk), .rst_n(rst_n), .dp_sel(sel), .dp_enable(en), .dp_write(wr),
        .dp_addr(addr), .dp_wdata(wdata), .dp_rdata(dp_rdata), .halt_req(halt_req),
        .hart_halted(halted), .hart_dbg_mode(dbgm), .inj_instr(inj_instr),
        .inj_valid(inj_valid), .inj_ready(ready), .hart_ebreak(ebk),
        .hart_exception(exc), .hcsr_addr(hcsr_addr), .hcsr_wen(hcsr_wen),
        .hcsr_ren(hcsr_ren), .hcsr_wdata(hcsr_wdata), .hcsr_rdata(hcsr_rdata),
        .hcsr_illegal(hcsr_illegal)
    );

    localparam logic [31:0] EBRK = 32'h00100073;
    int n_chk = 0, n_err = 0;
    logic [31:0] got[$];
    logic [31:0] expq[$];
    logic [31:0] gpr[32];
    int ready_mode = 0;
    bit exc_mode = 0;
    int pend = 0;
    logic prev_stall = 0;
    logic [31:0] prev_instr = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural hart: accepts injected words, runs the data CSR moves,
    // reports ebreak or exception two cycles after the closing ebreak
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                n_chk++;
                if (!(inj_valid && inj_instr == prev_instr)) begin
                    n_err++;
                    $display("FAIL R6: actual %h/%0b expected %h held", inj_instr, inj_valid, prev_instr);
                end
            end
            ebk = 0; exc = 0; m_wen = 0; m_ren = 0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    if (exc_mode) exc = 1; else ebk = 1;
                end
            end
            case (ready_mode)
                0: ready = 1;
                1: ready = ~ready;
                default: ready = 0;
            endcase
            prev_stall = inj_valid && !ready && !exc;
            prev_instr = inj_instr;
            if (inj_valid && ready) begin
                got.push_back(inj_instr);
                if (inj_instr == EBRK) pend = 2;
                else if (inj_instr[6:0] == 7'h73 && inj_instr[31:20] == 12'hbff) begin
                    if (inj_instr[14:12] == 3'b010) begin
                        m_ren = 1; m_addr = 12'hbff;
                        #1 gpr[inj_instr[11:7]] = hcsr_rdata;
                    end else if (inj_instr[14:12] == 3'b001) begin
                        m_wen = 1; m_addr = 12'hbff;
                        m_wdata = gpr[inj_instr[19:15]];
                    end
                end
            end
        end
    end

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1; en = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; en = 0; wr = 0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1; en = 1; wr = 0; addr = a;
        #1 d = dp_rdata;
        @(negedge clk);
        sel = 0; en = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            bus_rd(8'h16, v);
            if (!v[12]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_got(string req);
        chk({req, " count"}, 32'(got.size()), 32'(expq.size()));
        for (int i = 0; i < expq.size() && i < got.size(); i++)
            chk(req, got[i], expq[i]);
        got.delete();
        expq.delete();
    endtask

    task automatic chk_err(string req, logic [2:0] e);
        logic [31:0] v;
        bus_rd(8'h16, v);
        chk(req, v, 32'h02000001 | (32'(e) << 8));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 32; i++) gpr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 halt_req", 32'(halt_req), 0);
        chk("R1 inj_valid", 32'(inj_valid), 0);
        bus_rd(8'h04, v); chk("R1 data0", v, 0);
        bus_rd(8'h10, v); chk("R1 ctrl", v, 0);
        chk_err("R1 abstract status", 3'd0);
        // R3 hart description
        bus_rd(8'h12, v); chk("R3 hartinfo", v, 32'h00001bff);
        // R13 inactive: command ignored
        bus_wr(8'h10, 32'h80000000);
        chk("R13 halt_req inactive", 32'(halt_req), 0);
        halted = 1; dbgm = 1;
        bus_wr(8'h17, 32'h0023100a);
        repeat (6) @(negedge clk);
        chk_err("R13 no busy no error", 3'd0);
        chk_got("R13 no injection");
        // R2 activate and halt
        bus_wr(8'h10, 32'h80000001);
        chk("R2 halt_req", 32'(halt_req), 1);
        bus_rd(8'h11, v); chk("R2 status halted", v, 32'h302);
        halted = 0;
        bus_rd(8'h11, v); chk("R2 status running", v, 32'h2);
        halted = 1;
        // R4 write GPR 10 from data word
        bus_wr(8'h04, 32'h1234);
        bus_wr(8'h17, 32'h0023100a);
        wait_idle();
        expq.push_back(32'hbff02073 | (32'd10 << 7)); expq.push_back(EBRK);
        chk_got("R4 stream");
        chk("R4 gpr10", gpr[10], 32'h1234);
        chk_err("R4 no error", 3'd0);
        // R5 read GPR 11 into data word
        gpr[11] = 32'h5678;
        bus_wr(8'h17, 32'h0022100b);
        wait_idle();
        expq.push_back(32'hbff01073 | (32'd11 << 15)); expq.push_back(EBRK);
        chk_got("R5 stream");
        bus_rd(8'h04, v); chk("R5 data0", v, 32'h5678);
        // R6 transfer plus program buffer, toggling ready
        bus_wr(8'h20, 32'h00000013);
        bus_wr(8'h21, 32'h00a00093);
        ready_mode = 1;
        bus_wr(8'h17, 32'h00271005);
        wait_idle();
        expq.push_back(32'hbff022f3); expq.push_back(32'h00000013);
        expq.push_back(32'h00a00093); expq.push_back(EBRK);
        chk_got("R6 transfer+progbuf");
        bus_wr(8'h17, 32'h00240000);
        wait_idle();
        expq.push_back(32'h00000013); expq.push_back(32'h00a00093); expq.push_back(EBRK);
        chk_got("R6 progbuf only");
        ready_mode = 0;
        // R7 busy and collision
        ready_mode = 2;
        bus_wr(8'h17, 32'h0023100a);
        bus_rd(8'h16, v); chk("R7 busy", v, 32'h02001001);
        bus_wr(8'h17, 32'h0022100b);
        bus_rd(8'h16, v); chk("R7 collision error", v, 32'h02001101);
        ready_mode = 0;
        wait_idle();
        expq.push_back(32'hbff02073 | (32'd10 << 7)); expq.push_back(EBRK);
        chk_got("R7 single stream");
        bus_wr(8'h16, 32'h700);
        chk_err("R7 cleared", 3'd0);
        // R8 exception, sticky, per-bit clear; R10 ignore while error
        exc_mode = 1;
        bus_wr(8'h17, 32'h0023100a);
        wait_idle();
        expq.push_back(32'hbff02073 | (32'd10 << 7)); expq.push_back(EBRK);
        chk_got("R8 stream");
        chk_err("R8 exception error", 3'd3);
        exc_mode = 0;
        bus_wr(8'h17, 32'h0023100a);
        repeat (6) @(negedge clk);
        chk_got("R10 ignored while error");
        chk_err("R8 sticky", 3'd3);
        bus_wr(8'h16, 32'h100);
        chk_err("R8 partial clear", 3'd2);
        bus_wr(8'h16, 32'h700);
        chk_err("R8 full clear", 3'd0);
        // R9 rejections
        bus_wr(8'h17, 32'h00331000);
        repeat (4) @(negedge clk);
        chk_err("R9 bad size", 3'd2); chk_got("R9 bad size none");
        bus_wr(8'h16, 32'h700);
        bus_wr(8'h17, 32'h00231020);
        repeat (4) @(negedge clk);
        chk_err("R9 regno high", 3'd2); chk_got("R9 regno high none");
        bus_wr(8'h16, 32'h700);
        bus_wr(8'h17, 32'h00230fff);
        repeat (4) @(negedge clk);
        chk_err("R9 regno low", 3'd2); chk_got("R9 regno low none");
        bus_wr(8'h16, 32'h700);
        bus_wr(8'h17, 32'h01000000);
        repeat (4) @(negedge clk);
        chk_err("R9 type", 3'd2); chk_got("R9 type none");
        bus_wr(8'h16, 32'h700);
        bus_wr(8'h17, 32'h0023101f);
        wait_idle();
        expq.push_back(32'hbff02ff3); expq.push_back(EBRK);
        chk_got("R9 last register accepted");
        // R10 not halted
        halted = 0;
        bus_wr(8'h17, 32'h0023100a);
        repeat (4) @(negedge clk);
        chk_err("R10 not halted", 3'd4); chk_got("R10 none");
        bus_wr(8'h16, 32'h700);
        halted = 1;
        // R11 hart access in debug mode
        @(negedge clk);
        t_wen = 1; t_addr = 12'hbff; t_wdata = 32'hcafef00d;
        #1 chk("R11 no illegal", 32'(hcsr_illegal), 0);
        @(negedge clk);
        t_wen = 0; t_ren = 1;
        #1 chk("R11 hart read", hcsr_rdata, 32'hcafef00d);
        t_ren = 0;
        bus_rd(8'h04, v); chk("R11 data0", v, 32'hcafef00d);
        // R12 outside debug mode
        dbgm = 0;
        @(negedge clk);
        t_wen = 1; t_addr = 12'hbff; t_wdata = 32'h11111111;
        #1 chk("R12 illegal write", 32'(hcsr_illegal), 1);
        @(negedge clk);
        t_wen = 0; t_ren = 1;
        #1 chk("R12 illegal read", 32'(hcsr_illegal), 1);
        t_addr = 12'h300;
        #1 chk("R12 other address", 32'(hcsr_illegal), 0);
        t_ren = 0;
        bus_rd(8'h04, v); chk("R12 data0 kept", v, 32'hcafef00d);
        dbgm = 1;
        // R13 deactivate
        bus_wr(8'h10, 32'h80000000);
        chk("R13 halt_req dropped", 32'(halt_req), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule